// File: doc/BRIEF.md
# Video Processor Control-Port Decoder

This block is the processor-facing front end of a tile-based video processor. A host writes 16-bit words to a control port and reads or writes 16-bit words on a data port. A control word can do one of two things. It can load one of 24 eight-bit configuration registers in a single write. It can also start a two-word access command, which sets a six-bit operation code and a 16-bit byte address. The bits of the code and the address are spread over both command words.

After a command, each data-port access reaches one of three internal memories: video RAM, colour RAM or scroll RAM. Every access then steps the address by the value held in register 15. A 32-bit host store reaches the port as two 16-bit writes in consecutive cycles, and each of them lands at its own address. Read commands fetch the addressed word ahead of time, so a data read is answered in the next cycle. The register values are exported flat so that display, interrupt and transfer logic elsewhere can use them.

Top module: `vdp_port_front`

## Requirements
- R1: After reset, every register reads 0, no command is pending, the access code and address are 0, and `rvalid_o` is low.
- R2: A control write with bits 15..14 = `10` and no command pending loads value bits 7..0 into the register selected by bits 12..8. Register k appears on `regs_o[8k+7:8k]`. A write that selects register 24 to 31 changes nothing.
- R3: A control write that is not a register load and arrives with nothing pending is a first command word. It sets code bits 1..0 from bits 15..14 and address bits 13..0 from bits 13..0. It clears code bits 5..2 and address bits 15..14, and it sets the pending flag.
- R4: Any control write that arrives while a command is pending is the second word, even if its bits 15..14 are `10`. It sets code bits 5..2 from bits 7..4 and address bits 15..14 from bits 1..0. All its other bits are ignored, no register is loaded, and the pending flag clears.
- R5: Code map: 000001 writes video RAM, 000011 writes colour RAM, 000101 writes scroll RAM, 000000 reads video RAM, 001000 reads colour RAM, 000100 reads scroll RAM. Under any other code, a data write changes no memory and a data read returns 0.
- R6: Every data-port access adds register 15 to the address, modulo 2^16. This includes accesses that the code ignores.
- R7: Colour RAM has 64 entries of 9 bits, indexed by address bits 6..1. It keeps data bits 11..9, 7..5 and 3..1, and a colour read returns the written word ANDed with 0x0EEE.
- R8: Video RAM stores 16-bit words indexed by address bits 11..1 (bit 0 is ignored, and higher bits wrap). Scroll RAM stores 32 words of 16 bits indexed by address bits 5..1.
- R9: A data-port access made while a command is pending clears the pending flag, so the next control write is decoded afresh.
- R10: A data read returns its word on `rdata_o` with `rvalid_o` high in the cycle after the strobe. This includes a read in the cycle right after a command word.
- R11: When strobes coincide, a control write wins over a data write, and a data write wins over a data read. A losing strobe has no effect at all: no store, no increment, no read response.
- R12: Two data writes in consecutive cycles, as a 32-bit store produces, each store their word and each apply their own increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control-port write strobe |
| data_wr_i | input | 1 | Data-port write strobe |
| data_rd_i | input | 1 | Data-port read strobe |
| wdata_i | input | 16 | Write word for either port |
| rdata_o | output | 16 | Data-port read word |
| rvalid_o | output | 1 | Read word valid, one cycle after the read strobe |
| regs_o | output | 192 | Flattened register file, register k at bits 8k+7..8k |

## Verification
Two events can land in the same cycle. The first is a data read issued in the cycle right after a command word, when the prefetch of the new address has not yet been stored. The bench provokes it with back-to-back command and read calls, both directed and random, and compares the returned word against a bench-side model of the three memories. The second is a control write or data write that coincides with another strobe. Random collisions are injected, and the bench judges them by reading the memories back and comparing `regs_o`. Losing strobes must leave neither a stored word nor an address step.

// File: rtl/vdp_pkg.sv
`timescale 1ns/1ps
package vdp_pkg;
  localparam int REG_FIELD_W = 5;

  typedef enum logic [2:0] {
    K_NONE, K_VRAM_WR, K_CRAM_WR, K_VS_WR, K_VRAM_RD, K_CRAM_RD, K_VS_RD
  } kind_e;

  function automatic kind_e decode_kind(input logic [5:0] cd);
    case (cd)
      6'b000001: return K_VRAM_WR;
      6'b000011: return K_CRAM_WR;
      6'b000101: return K_VS_WR;
      6'b000000: return K_VRAM_RD;
      6'b001000: return K_CRAM_RD;
      6'b000100: return K_VS_RD;
      default:   return K_NONE;
    endcase
  endfunction

  function automatic logic is_read(input kind_e k);
    return (k == K_VRAM_RD) || (k == K_CRAM_RD) || (k == K_VS_RD);
  endfunction
endpackage

// File: rtl/vdp_regfile.sv
`timescale 1ns/1ps
module vdp_regfile #(
  parameter int N_REGS  = 24,
  parameter int IDX_W   = 5,
  parameter int INC_REG = 15
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [7:0]            val_i,
  output logic [N_REGS*8-1:0]   regs_o,
  output logic [7:0]            inc_o
);
  logic [N_REGS-1:0][7:0] regs_q;

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[g] <= 8'h00;
      else if (we_i && idx_i == IDX_W'(g))      regs_q[g] <= val_i;
    end
  end

  assign regs_o = regs_q;
  assign inc_o  = regs_q[INC_REG];

  // R2: out-of-range or absent loads leave the file untouched
  a_r2_no_load_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || int'(idx_i) >= N_REGS) |=> $stable(regs_q));
  a_r2_load_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(idx_i) == INC_REG) |=> (inc_o == $past(val_i)));
endmodule

// File: rtl/vdp_cmd_latch.sv
`timescale 1ns/1ps
module vdp_cmd_latch
  import vdp_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ctrl_we_i,
  input  logic [15:0]            word_i,
  input  logic                   data_acc_i,
  input  logic [7:0]             inc_i,
  output logic                   reg_we_o,
  output logic [REG_FIELD_W-1:0] reg_idx_o,
  output logic [7:0]             reg_val_o,
  output logic                   cmd_o,
  output logic [5:0]             code_o,
  output logic [15:0]            addr_o,
  output logic                   pending_o
);
  logic        pending_q;
  logic [5:0]  code_q;
  logic [15:0] addr_q;
  logic        is_reg;

  assign is_reg    = !pending_q && (word_i[15:14] == 2'b10);
  assign reg_we_o  = ctrl_we_i && is_reg;
  assign reg_idx_o = word_i[8 +: REG_FIELD_W];
  assign reg_val_o = word_i[7:0];
  assign cmd_o     = ctrl_we_i && !is_reg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      code_q    <= '0;
      addr_q    <= '0;
    end else if (ctrl_we_i) begin
      if (pending_q) begin
        code_q[5:2]    <= word_i[7:4];
        addr_q[15:14]  <= word_i[1:0];
        pending_q      <= 1'b0;
      end else if (!is_reg) begin
        code_q    <= {4'b0000, word_i[15:14]};
        addr_q    <= {2'b00, word_i[13:0]};
        pending_q <= 1'b1;
      end
    end else if (data_acc_i) begin
      addr_q    <= addr_q + {8'h00, inc_i};
      pending_q <= 1'b0;
    end
  end

  assign code_o    = code_q;
  assign addr_o    = addr_q;
  assign pending_o = pending_q;

  a_r3_first_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !pending_o && word_i[15:14] != 2'b10) |=> (pending_o && code_o[5:2] == 4'b0));
  a_r4_second_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && pending_o) |=> !pending_o);
  a_r4_second_no_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |-> !reg_we_o);
  a_r9_data_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc_i && !ctrl_we_i) |=> !pending_o);
endmodule

// File: rtl/vdp_ram.sv
`timescale 1ns/1ps
module vdp_ram #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/vdp_port_front.sv
`timescale 1ns/1ps
module vdp_port_front
  import vdp_pkg::*;
#(
  parameter int N_REGS   = 24,
  parameter int INC_REG  = 15,
  parameter int VRAM_WAW = 11,
  parameter int CRAM_AW  = 6,
  parameter int VSRAM_AW = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ctrl_wr_i,
  input  logic                 data_wr_i,
  input  logic                 data_rd_i,
  input  logic [15:0]          wdata_i,
  output logic [15:0]          rdata_o,
  output logic                 rvalid_o,
  output logic [N_REGS*8-1:0]  regs_o
);
  localparam int CRAM_DW = 9;

  logic wr_v, rd_v, acc_v;
  assign wr_v  = data_wr_i && !ctrl_wr_i;
  assign rd_v  = data_rd_i && !ctrl_wr_i && !data_wr_i;
  assign acc_v = wr_v || rd_v;

  logic                   reg_we, cmd_acc, pending;
  logic [REG_FIELD_W-1:0] reg_idx;
  logic [7:0]             reg_val, inc;
  logic [5:0]             code;
  logic [15:0]            addr;

  vdp_cmd_latch u_cmd (
    .clk_i, .rst_ni,
    .ctrl_we_i (ctrl_wr_i), .word_i (wdata_i), .data_acc_i (acc_v), .inc_i (inc),
    .reg_we_o (reg_we), .reg_idx_o (reg_idx), .reg_val_o (reg_val),
    .cmd_o (cmd_acc), .code_o (code), .addr_o (addr), .pending_o (pending)
  );

  vdp_regfile #(.N_REGS(N_REGS), .IDX_W(REG_FIELD_W), .INC_REG(INC_REG)) u_regs (
    .clk_i, .rst_ni, .we_i (reg_we), .idx_i (reg_idx), .val_i (reg_val),
    .regs_o, .inc_o (inc)
  );

  kind_e kind;
  assign kind = decode_kind(code);

  logic                vram_we, cram_we, vs_we;
  logic [VRAM_WAW-1:0] vram_idx;
  logic [CRAM_AW-1:0]  cram_idx;
  logic [VSRAM_AW-1:0] vs_idx;
  logic [15:0]         vram_q, vs_q, cram_word;
  logic [CRAM_DW-1:0]  cram_q, cram_d;

  assign vram_we  = wr_v && kind == K_VRAM_WR;
  assign cram_we  = wr_v && kind == K_CRAM_WR;
  assign vs_we    = wr_v && kind == K_VS_WR;
  assign vram_idx = addr[VRAM_WAW:1];
  assign cram_idx = addr[CRAM_AW:1];
  assign vs_idx   = addr[VSRAM_AW:1];
  assign cram_d   = {wdata_i[11:9], wdata_i[7:5], wdata_i[3:1]};
  assign cram_word = {4'h0, cram_q[8:6], 1'b0, cram_q[5:3], 1'b0, cram_q[2:0], 1'b0};

  vdp_ram #(.DW(16), .AW(VRAM_WAW)) u_vram (
    .clk_i, .we_i (vram_we), .waddr_i (vram_idx), .wdata_i (wdata_i),
    .raddr_i (vram_idx), .rdata_o (vram_q));
  vdp_ram #(.DW(CRAM_DW), .AW(CRAM_AW)) u_cram (
    .clk_i, .we_i (cram_we), .waddr_i (cram_idx), .wdata_i (cram_d),
    .raddr_i (cram_idx), .rdata_o (cram_q));
  vdp_ram #(.DW(16), .AW(VSRAM_AW)) u_vsram (
    .clk_i, .we_i (vs_we), .waddr_i (vs_idx), .wdata_i (wdata_i),
    .raddr_i (vs_idx), .rdata_o (vs_q));

  logic [15:0] live;
  always_comb begin
    case (kind)
      K_VRAM_RD: live = vram_q;
      K_CRAM_RD: live = cram_word;
      K_VS_RD:   live = vs_q;
      default:   live = 16'h0000;
    endcase
  end

  // prefetch: refresh after any address or code change
  logic        fetch_q;
  logic [15:0] buf_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q  <= 1'b1;
      buf_q    <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      fetch_q  <= cmd_acc || acc_v;
      if (fetch_q) buf_q <= live;
      rvalid_o <= rd_v;
      if (rd_v) rdata_o <= !is_read(kind) ? 16'h0000 : (fetch_q ? live : buf_q);
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_v |=> rvalid_o);
  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_v |=> !rvalid_o);
  a_r7_cram_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_v && kind == K_CRAM_RD) |=> ((rdata_o & 16'hF111) == 16'h0000));
  a_r5_none_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_v && kind == K_NONE) |=> (rdata_o == 16'h0000));
  a_r11_ctrl_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |-> !(vram_we || cram_we || vs_we));
  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_v |=> (addr == $past(addr) + {8'h00, $past(inc)}));
  a_r9_pending_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending && acc_v) |=> !pending);
endmodule

// File: tb/vdp_port_front_test.sv
`timescale 1ns/1ps
module vdp_port_front_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctrl_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [15:0]  wdata = '0;
  logic [15:0]  rdata;
  logic         rvalid;
  logic [191:0] regs;

  always #4 clk = ~clk;

  vdp_port_front uut (
    .clk_i (clk), .rst_ni (rst_n), .ctrl_wr_i (ctrl_wr), .data_wr_i (data_wr),
    .data_rd_i (data_rd), .wdata_i (wdata), .rdata_o (rdata), .rvalid_o (rvalid),
    .regs_o (regs));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [15:0] m_vram [2048];
  logic [15:0] m_cram [64];
  logic [15:0] m_vs   [32];
  logic [7:0]  m_regs [24];
  logic [15:0] m_addr;
  logic [5:0]  m_code;
  logic        m_pend;

  task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [191:0] regs_exp();
    logic [191:0] v;
    for (int k = 0; k < 24; k++) v[8*k +: 8] = m_regs[k];
    return v;
  endfunction

  function automatic logic [15:0] model_read();
    case (m_code)
      6'b000000: return m_vram[m_addr[11:1]];
      6'b001000: return m_cram[m_addr[6:1]];
      6'b000100: return m_vs[m_addr[5:1]];
      default:   return 16'h0000;
    endcase
  endfunction

  task automatic model_write(input logic [15:0] d);
    case (m_code)
      6'b000001: m_vram[m_addr[11:1]] = d;
      6'b000011: m_cram[m_addr[6:1]]  = d & 16'h0EEE;
      6'b000101: m_vs[m_addr[5:1]]    = d;
      default: ;
    endcase
  endtask

  // one clock cycle of stimulus, model updated and reads checked
  task automatic op(input logic c, input logic w, input logic r, input logic [15:0] d,
                    input string req);
    logic [15:0] exp_rd;
    logic        is_rd;
    is_rd  = r && !c && !w;
    exp_rd = model_read();
    ctrl_wr = c; data_wr = w; data_rd = r; wdata = d;
    @(negedge clk);
    ctrl_wr = 1'b0; data_wr = 1'b0; data_rd = 1'b0;
    if (c) begin
      if (m_pend) begin
        m_code[5:2] = d[7:4]; m_addr[15:14] = d[1:0]; m_pend = 1'b0;
      end else if (d[15:14] == 2'b10) begin
        if (d[12:8] < 5'd24) m_regs[d[12:8]] = d[7:0];
      end else begin
        m_code = {4'b0, d[15:14]}; m_addr = {2'b0, d[13:0]}; m_pend = 1'b1;
      end
    end else if (w || r) begin
      if (w) model_write(d);
      m_addr = m_addr + {8'h00, m_regs[15]};
      m_pend = 1'b0;
    end
    if (is_rd) check({req, " read word"}, {176'b0, rvalid, rdata}, {176'b0, 1'b1, exp_rd});
    else if (rvalid !== 1'b0) check({req, " no response"}, {191'b0, rvalid}, 192'b0);
  endtask

  task automatic reg_wr(input logic [4:0] idx, input logic [7:0] v, input string req);
    op(1'b1, 1'b0, 1'b0, {3'b100, idx, v}, req);
  endtask

  task automatic cmd(input logic [5:0] cd, input logic [15:0] a, input string req);
    op(1'b1, 1'b0, 1'b0, {cd[1:0], a[13:0]}, req);
    op(1'b1, 1'b0, 1'b0, {8'h00, cd[5:2], 2'b00, a[15:14]}, req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, b;
    void'($urandom(32'd4242));
    for (int k = 0; k < 24; k++) m_regs[k] = 8'h00;
    m_addr = '0; m_code = '0; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 registers", regs, 192'b0);
    check("R1 rvalid", {191'b0, rvalid}, 192'b0);

    // R2 loads and out-of-range index
    reg_wr(5'd15, 8'd2, "R2");
    check("R2 reg15", {184'b0, regs[127:120]}, 192'd2);
    reg_wr(5'd5, 8'hAB, "R2");
    reg_wr(5'd24, 8'h55, "R2");
    reg_wr(5'd31, 8'h77, "R2");
    check("R2 bank after idx 24/31", regs, regs_exp());

    // fill all memories (R8 video/scroll, R7 colour, R12 back-to-back)
    cmd(6'b000001, 16'h0000, "R8");
    for (int i = 0; i < 2048; i++) op(1'b0, 1'b1, 1'b0, 16'($urandom), "R12");
    cmd(6'b000011, 16'h0000, "R7");
    for (int i = 0; i < 64; i++) op(1'b0, 1'b1, 1'b0, 16'($urandom), "R7");
    cmd(6'b000101, 16'h0000, "R8");
    for (int i = 0; i < 32; i++) op(1'b0, 1'b1, 1'b0, 16'($urandom), "R8");

    // R7 colour packing, R10 read right after command word
    cmd(6'b000011, 16'h0004, "R7");
    op(1'b0, 1'b1, 1'b0, 16'hFFFF, "R7");
    cmd(6'b001000, 16'h0004, "R7");
    op(1'b0, 1'b0, 1'b1, 16'h0, "R10 prefetch same cycle");
    check("R7 colour value", {176'b0, rdata}, {176'b0, 16'h0EEE});

    // R12 32-bit pair, R6 increments
    a = 16'h1234; b = 16'hBEEF;
    cmd(6'b000001, 16'h0100, "R12");
    op(1'b0, 1'b1, 1'b0, a, "R12");
    op(1'b0, 1'b1, 1'b0, b, "R12");
    cmd(6'b000000, 16'h0100, "R12");
    op(1'b0, 1'b0, 1'b0, 16'h0, "R10");
    op(1'b0, 1'b0, 1'b1, 16'h0, "R12 first half");
    check("R12 first half", {176'b0, rdata}, {176'b0, a});
    op(1'b0, 1'b0, 1'b1, 16'h0, "R12 second half");
    check("R12 second half", {176'b0, rdata}, {176'b0, b});

    // R6 wrap across 0xFFFF with increment 4
    reg_wr(5'd15, 8'd4, "R6");
    cmd(6'b000101, 16'hFFFE, "R6");
    op(1'b0, 1'b1, 1'b0, 16'hA5A5, "R6");
    op(1'b0, 1'b1, 1'b0, 16'h5A5A, "R6");
    cmd(6'b000100, 16'h0002, "R6");
    op(1'b0, 1'b0, 1'b1, 16'h0, "R6 wrapped store");
    check("R6 wrapped store", {176'b0, rdata}, {176'b0, 16'h5A5A});

    // R8 video bit 0 ignored
    reg_wr(5'd15, 8'd0, "R8");
    cmd(6'b000001, 16'h0201, "R8");
    op(1'b0, 1'b1, 1'b0, 16'hC0DE, "R8");
    cmd(6'b000000, 16'h0200, "R8");
    op(1'b0, 1'b0, 1'b1, 16'h0, "R8 bit0");
    check("R8 bit0 ignored", {176'b0, rdata}, {176'b0, 16'hC0DE});

    // R4 second word with top bits 10 does not load a register
    op(1'b1, 1'b0, 1'b0, 16'h4010, "R4");
    op(1'b1, 1'b0, 1'b0, 16'h8F03, "R4");
    check("R4 no register load", regs, regs_exp());

    // R9 data access drops the pending half command
    op(1'b1, 1'b0, 1'b0, 16'h4020, "R9");
    op(1'b0, 1'b1, 1'b0, 16'h7777, "R9");
    reg_wr(5'd7, 8'h3C, "R9");
    check("R9 load after drop", {184'b0, regs[63:56]}, 192'h3C);

    // R5 unknown code: no store, read returns zero
    cmd(6'b010001, 16'h0100, "R5");
    op(1'b0, 1'b1, 1'b0, 16'hDEAD, "R5");
    op(1'b0, 1'b0, 1'b1, 16'h0, "R5 unknown read zero");
    cmd(6'b000000, 16'h0100, "R5");
    op(1'b0, 1'b0, 1'b1, 16'h0, "R5 memory untouched");
    check("R5 memory untouched", {176'b0, rdata}, {176'b0, a});

    // R11 collisions
    reg_wr(5'd15, 8'd2, "R11");
    cmd(6'b000001, 16'h0300, "R11");
    op(1'b1, 1'b1, 1'b0, 16'h8A11, "R11 ctrl beats write");
    check("R11 ctrl loaded", {184'b0, regs[87:80]}, 192'h11);
    op(1'b0, 1'b1, 1'b1, 16'h9999, "R11 write beats read");
    cmd(6'b000000, 16'h0300, "R11");
    op(1'b0, 1'b0, 1'b1, 16'h0, "R11 stored once");
    check("R11 stored at base", {176'b0, rdata}, {176'b0, 16'h9999});

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [15:0] d;
      sel = int'($urandom % 100);
      d = 16'($urandom);
      if (sel < 8) begin
        if ($urandom % 3 == 0) reg_wr(5'd15, 8'($urandom % 5), "R6 rand");
        else reg_wr(5'($urandom), d[7:0], "R2 rand");
      end else if (sel < 22) begin
        logic [5:0] cd;
        case ($urandom % 7)
          0: cd = 6'b000001; 1: cd = 6'b000011; 2: cd = 6'b000101;
          3: cd = 6'b000000; 4: cd = 6'b001000; 5: cd = 6'b000100;
          default: cd = 6'b010001;
        endcase
        cmd(cd, d, "R3 rand");
      end else if (sel < 55) op(1'b0, 1'b1, 1'b0, d, "R12 rand");
      else if (sel < 92) op(1'b0, 1'b0, 1'b1, d, "R10 rand");
      else if (sel < 95) op(1'b0, 1'b1, 1'b1, d, "R11 rand");
      else if (sel < 98) op(1'b1, 1'b0, 1'b1, {3'b100, 5'($urandom % 24), d[7:0]}, "R11 rand");
      else op(1'b1, 1'b0, 1'b0, {2'b01, d[13:0]}, "R9 rand half");
      if (i % 200 == 199) check("R2 rand bank", regs, regs_exp());
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule